// File: doc/BRIEF.md
# Two-Processor Mailbox Channel Controller

This block lets two processors signal each other over a set of one-bit channels. Every channel has one "occupied" flag per processor. A processor raises its own flag to tell its peer that a message is waiting. The peer takes the message and acknowledges it, and the acknowledge lowers the sender's flag again. Each processor has its own register bank, which holds an interrupt-enable word, a per-channel mask word, a write-only set/acknowledge word and a status word showing its own flags.

Each processor gets two level-sensitive interrupt lines. The receive line is high while the peer has an unmasked occupied channel. The transmit line is high while one of the processor's own unmasked channels is free again. Both processors reach the register space through two identical word-addressed write/read ports, and either port can address either bank. Two read-only words report the channel count and the block revision.

Top module: `ipc_mailbox`

## Requirements
- R1: Bank p (0 or 1) sits at byte address 0x10·p. The enable word is at +0x0, the mask word at +0x4, the set/acknowledge word at +0x8 and the own-status word at +0xC. Read data for the address on a port appears on that port's read bus one clock later.
- R2: In the enable word, bit 0 enables the receive interrupt and bit 16 enables the transmit interrupt. All other bits read 0, and both enables reset to 0.
- R3: In the mask word, bit n masks the receive condition of channel n and bit 16+n masks its transmit condition, where 1 means masked. All implemented mask bits reset to 1.
- R4: Writing 1 to bit 16+n of bank p's set/acknowledge word sets processor p's flag for channel n. Status bit n of bank p then reads 1.
- R5: Writing 1 to bit n of bank p's set/acknowledge word clears the peer processor's flag for channel n. A 0 in any bit of that word changes nothing.
- R6: The set/acknowledge word always reads 0.
- R7: irq_rx[p] is 1 exactly when receive is enabled in bank p and the peer has an occupied channel whose receive mask bit in bank p is 0. The line follows the state with one register stage.
- R8: irq_tx[p] is 1 exactly when transmit is enabled in bank p and some implemented channel has its own flag clear and its transmit mask bit in bank p at 0. The line follows the state with one register stage.
- R9: Address 0x3F0 reads the channel count in bits 7:0. Address 0x3F4 reads the minor revision in bits 3:0 and the major revision in bits 7:4. Unmapped addresses read 0.
- R10: If a set and an acknowledge reach the same flag in the same cycle, whether from one port or from both, the flag ends up set.
- R11: If both ports write the same enable or mask word in the same cycle, port 0's data is kept.
- R12: Bits for channels at or above the channel count are neither stored nor settable, and they read 0 in the mask and status words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 2 | Write strobe, one per access port |
| host_addr | input | 2*AW | Byte address per port, port q in bits [q*AW +: AW] |
| host_wdata | input | 64 | Write data per port, port q in bits [q*32 +: 32] |
| host_rdata | output | 64 | Registered read data per port |
| irq_rx | output | 2 | Receive-occupied interrupt per processor |
| irq_tx | output | 2 | Transmit-free interrupt per processor |

## Verification
The flags are driven through a full message cycle: bank 0 raises a channel, bank 1 sees a receive interrupt, bank 1 acknowledges, and bank 0 sees a transmit-free interrupt. This pins down which bank's flag feeds which processor's lines. The mask and enable words are toggled while the flags stay unchanged, so gating can be told apart from flag state. Acknowledges that write only zeros, and sets aimed at channels beyond the count, show that such writes are ignored. Same-cycle writes from both ports separate the set-over-acknowledge rule from the port-0-wins rule.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;
  localparam int DW    = 32;
  localparam int TXB   = 16;
  localparam int MAXCH = 16;
  localparam logic [1:0] OFF_CTRL   = 2'd0;
  localparam logic [1:0] OFF_MASK   = 2'd1;
  localparam logic [1:0] OFF_SETCLR = 2'd2;
  localparam logic [1:0] OFF_STAT   = 2'd3;
  localparam int ADDR_HWCFG = 'h3F0;
  localparam int ADDR_VER   = 'h3F4;
endpackage

// File: rtl/ipcmb_ctlbank.sv
module ipcmb_ctlbank #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctrl_we,
  input  logic [31:0]    ctrl_wd,
  input  logic           mask_we,
  input  logic [31:0]    mask_wd,
  output logic           rx_en,
  output logic           tx_en,
  output logic [NCH-1:0] mask_rx,
  output logic [NCH-1:0] mask_tx
);
  import ipcmb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      mask_rx <= '1;
      mask_tx <= '1;
    end else begin
      if (ctrl_we) begin
        rx_en <= ctrl_wd[0];
        tx_en <= ctrl_wd[TXB];
      end
      if (mask_we) begin
        mask_rx <= mask_wd[NCH-1:0];
        mask_tx <= mask_wd[TXB +: NCH];
      end
    end
  end
endmodule

// File: rtl/ipcmb_occupancy.sv
module ipcmb_occupancy #(
  parameter int NCH = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0][NCH-1:0] set_v,
  input  logic [1:0][NCH-1:0] clr_v,
  output logic [1:0][NCH-1:0] occ
);
  for (genvar p = 0; p < 2; p++) begin : g_proc
    always_ff @(posedge clk) begin
      if (rst) occ[p] <= '0;
      else     occ[p] <= (occ[p] & ~clr_v[p]) | set_v[p];
    end
  end
endmodule

// File: rtl/ipcmb_irqgen.sv
module ipcmb_irqgen #(
  parameter int NCH = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          rx_en,
  input  logic [1:0]          tx_en,
  input  logic [1:0][NCH-1:0] mask_rx,
  input  logic [1:0][NCH-1:0] mask_tx,
  input  logic [1:0][NCH-1:0] occ,
  output logic [1:0]          irq_rx,
  output logic [1:0]          irq_tx
);
  for (genvar p = 0; p < 2; p++) begin : g_proc
    localparam int PEER = 1 - p;
    logic rx_hit, tx_hit;
    assign rx_hit = |(occ[PEER] & ~mask_rx[p]);
    assign tx_hit = |(~occ[p] & ~mask_tx[p]);
    always_ff @(posedge clk) begin
      if (rst) begin
        irq_rx[p] <= 1'b0;
        irq_tx[p] <= 1'b0;
      end else begin
        irq_rx[p] <= rx_en[p] & rx_hit;
        irq_tx[p] <= tx_en[p] & tx_hit;
      end
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int         NCH       = 6,
  parameter int         AW        = 12,
  parameter logic [3:0] VER_MAJOR = 4'd1,
  parameter logic [3:0] VER_MINOR = 4'd2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      host_wr,
  input  logic [2*AW-1:0] host_addr,
  input  logic [63:0]     host_wdata,
  output logic [63:0]     host_rdata,
  output logic [1:0]      irq_rx,
  output logic [1:0]      irq_tx
);
  import ipcmb_pkg::*;

  logic [1:0][AW-1:0]  a_p;
  logic [1:0][31:0]    wd_p;
  logic [1:0]          in_bank;
  logic [1:0]          bsel;
  logic [1:0][1:0]     off;
  logic [1:0][1:0]     hit;      // [port][bank]

  logic [1:0]          ctrl_we, mask_we;
  logic [1:0][31:0]    ctrl_wd, mask_wd;
  logic [1:0][NCH-1:0] set_v, clr_v, occ_q;
  logic [1:0]          rx_en, tx_en;
  logic [1:0][NCH-1:0] mask_rx, mask_tx;
  logic [1:0][31:0]    rmux;

  for (genvar q = 0; q < 2; q++) begin : g_port
    assign a_p[q]     = host_addr[q*AW +: AW];
    assign wd_p[q]    = host_wdata[q*32 +: 32];
    assign in_bank[q] = (a_p[q][AW-1:5] == '0);
    assign bsel[q]    = a_p[q][4];
    assign off[q]     = a_p[q][3:2];
    for (genvar b = 0; b < 2; b++) begin : g_bank
      assign hit[q][b] = host_wr[q] & in_bank[q] & (bsel[q] == b[0]);
    end
  end

  // set/acknowledge decode, both ports OR-merged; set priority lives in the flag update
  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int q = 0; q < 2; q++) begin
      for (int b = 0; b < 2; b++) begin
        if (hit[q][b] && off[q] == OFF_SETCLR) begin
          set_v[b]   = set_v[b]   | wd_p[q][TXB +: NCH];
          clr_v[1-b] = clr_v[1-b] | wd_p[q][NCH-1:0];
        end
      end
    end
  end

  // enable/mask write select: port 0 wins on collision
  for (genvar b = 0; b < 2; b++) begin : g_wsel
    logic c0, c1, m0, m1;
    assign c0 = hit[0][b] && off[0] == OFF_CTRL;
    assign c1 = hit[1][b] && off[1] == OFF_CTRL;
    assign m0 = hit[0][b] && off[0] == OFF_MASK;
    assign m1 = hit[1][b] && off[1] == OFF_MASK;
    assign ctrl_we[b] = c0 | c1;
    assign mask_we[b] = m0 | m1;
    assign ctrl_wd[b] = c0 ? wd_p[0] : wd_p[1];
    assign mask_wd[b] = m0 ? wd_p[0] : wd_p[1];

    ipcmb_ctlbank #(.NCH(NCH)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .ctrl_we (ctrl_we[b]),
      .ctrl_wd (ctrl_wd[b]),
      .mask_we (mask_we[b]),
      .mask_wd (mask_wd[b]),
      .rx_en   (rx_en[b]),
      .tx_en   (tx_en[b]),
      .mask_rx (mask_rx[b]),
      .mask_tx (mask_tx[b])
    );
  end

  ipcmb_occupancy #(.NCH(NCH)) u_occ (
    .clk   (clk),
    .rst   (rst),
    .set_v (set_v),
    .clr_v (clr_v),
    .occ   (occ_q)
  );

  ipcmb_irqgen #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .rx_en   (rx_en),
    .tx_en   (tx_en),
    .mask_rx (mask_rx),
    .mask_tx (mask_tx),
    .occ     (occ_q),
    .irq_rx  (irq_rx),
    .irq_tx  (irq_tx)
  );

  // read multiplexer, registered per port
  always_comb begin
    for (int q = 0; q < 2; q++) begin
      rmux[q] = '0;
      if (in_bank[q]) begin
        case (off[q])
          OFF_CTRL: begin
            rmux[q][0]   = rx_en[bsel[q]];
            rmux[q][TXB] = tx_en[bsel[q]];
          end
          OFF_MASK: begin
            rmux[q][NCH-1:0]   = mask_rx[bsel[q]];
            rmux[q][TXB +: NCH] = mask_tx[bsel[q]];
          end
          OFF_STAT: rmux[q][NCH-1:0] = occ_q[bsel[q]];
          default:  rmux[q] = '0;
        endcase
      end else if (a_p[q] == AW'(ADDR_HWCFG)) begin
        rmux[q][7:0] = 8'(NCH);
      end else if (a_p[q] == AW'(ADDR_VER)) begin
        rmux[q][7:0] = {VER_MAJOR, VER_MINOR};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= {rmux[1], rmux[0]};
  end
endmodule

// File: rtl/ipcmb_checker.sv
module ipcmb_checker #(
  parameter int NCH = 6,
  parameter int AW  = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [2*AW-1:0]     host_addr,
  input logic [63:0]         host_rdata,
  input logic [1:0][NCH-1:0] occ,
  input logic [1:0][NCH-1:0] set_v,
  input logic [1:0][NCH-1:0] clr_v,
  input logic [1:0]          rx_en,
  input logic [1:0]          tx_en,
  input logic [1:0]          irq_rx,
  input logic [1:0]          irq_tx
);
  AST_SETCLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_addr[AW-1:0] == AW'('h008)) |=> (host_rdata[31:0] == 32'd0)); // R6

  AST_HWCFG_COUNT: assert property (@(posedge clk) disable iff (rst)
    (host_addr[AW-1:0] == AW'('h3F0)) |=> (host_rdata[7:0] == 8'(NCH))); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> ((occ & $past(set_v)) == $past(set_v))); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_v & ~set_v)) |=> ((occ & $past(clr_v & ~set_v)) == '0)); // R5

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (set_v == '0 && clr_v == '0) |=> $stable(occ)); // R4

  AST_RX0_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_rx[0] |-> $past(rx_en[0])); // R7

  AST_RX1_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_rx[1] |-> $past(rx_en[1])); // R7

  AST_TX0_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_tx[0] |-> $past(tx_en[0])); // R8

  AST_TX1_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_tx[1] |-> $past(tx_en[1])); // R8
endmodule

bind ipc_mailbox ipcmb_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .occ        (occ_q),
  .set_v      (set_v),
  .clr_v      (clr_v),
  .rx_en      (rx_en),
  .tx_en      (tx_en),
  .irq_rx     (irq_rx),
  .irq_tx     (irq_tx)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      host_wr = '0;
  logic [2*AW-1:0] host_addr = '0;
  logic [63:0]     host_wdata = '0;
  logic [63:0]     host_rdata;
  logic [1:0]      irq_rx, irq_tx;

  always #5 clk = ~clk;

  ipc_mailbox u_dut (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_rx     (irq_rx),
    .irq_tx     (irq_tx)
  );

  typedef struct {
    bit          is_irq;
    int          port;
    logic [31:0] exp;
    string       tag;
    int          due;
  } item_t;

  item_t sb[$];
  item_t it;
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares items as their cycle comes up
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      logic [31:0] act;
      it = sb.pop_front();
      if (it.is_irq) act = {28'd0, irq_tx, irq_rx};
      else           act = host_rdata[it.port*32 +: 32];
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd(input int q, input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_addr[q*AW +: AW] = AW'(addr);
    sb.push_back('{0, q, exp, tag, cyc + 1});
  endtask

  task automatic chk_irq(input logic [3:0] exp, input string tag);
    @(negedge clk);
    sb.push_back('{1, 0, {28'd0, exp}, tag, cyc + 1});
  endtask

  task automatic wr(input int q, input int addr, input logic [31:0] d);
    @(negedge clk);
    host_wr[q] = 1'b1;
    host_addr[q*AW +: AW] = AW'(addr);
    host_wdata[q*32 +: 32] = d;
    @(negedge clk);
    host_wr[q] = 1'b0;
  endtask

  task automatic wr2(input int a0, input logic [31:0] d0, input int a1, input logic [31:0] d1);
    @(negedge clk);
    host_wr = 2'b11;
    host_addr = {AW'(a1), AW'(a0)};
    host_wdata = {d1, d0};
    @(negedge clk);
    host_wr = 2'b00;
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(0, 'h000, 32'h0, "R2 reset enable bank0");
    rd(0, 'h004, 32'h003F003F, "R3 reset mask bank0");
    rd(1, 'h014, 32'h003F003F, "R3 reset mask bank1");
    rd(0, 'h00C, 32'h0, "R1 reset status bank0");
    chk_irq(4'h0, "R7 reset irq lines");

    // read-only words
    rd(0, 'h3F0, 32'h6, "R9 channel count");
    rd(1, 'h3F4, 32'h12, "R9 revision");
    rd(0, 'h100, 32'h0, "R9 unmapped");

    // enable word and mask width
    wr(0, 'h000, 32'hFFFF_FFFF);
    rd(0, 'h000, 32'h0001_0001, "R2 enable bits only");
    wr(1, 'h004, 32'hFFFF_FFFF);
    rd(1, 'h004, 32'h003F003F, "R12 mask unimplemented bits");

    // set channel 2 on bank0
    wr(0, 'h008, 32'h1 << 18);
    rd(0, 'h00C, 32'h4, "R4 bank0 flag ch2 set");
    rd(1, 'h01C, 32'h0, "R1 bank1 status untouched");
    rd(0, 'h008, 32'h0, "R6 set/ack reads zero");

    // receive interrupt on processor 1
    wr(1, 'h010, 32'h1);
    wr(1, 'h014, 32'hFFFF_FFFB);
    chk_irq(4'h2, "R7 irq_rx1 on peer ch2");
    wr(1, 'h014, 32'hFFFF_FFFF);
    chk_irq(4'h0, "R7 irq_rx1 masked");
    wr(1, 'h014, 32'hFFFF_FFFB);
    wr(1, 'h010, 32'h0);
    chk_irq(4'h0, "R7 irq_rx1 disabled");
    wr(1, 'h010, 32'h1);
    chk_irq(4'h2, "R7 irq_rx1 re-enabled");

    // transmit-free on processor 0
    wr(0, 'h004, 32'hFFFB_FFFF);
    chk_irq(4'h2, "R8 irq_tx0 low while ch2 occupied");
    wr(1, 'h018, 32'h4);
    chk_irq(4'h4, "R8 irq_tx0 after ack, R7 rx1 drops");
    rd(0, 'h00C, 32'h0, "R5 ack cleared bank0 ch2");

    // zero writes ignored
    wr(0, 'h008, 32'h1 << 17);
    rd(0, 'h00C, 32'h2, "R4 bank0 ch1 set");
    wr(1, 'h018, 32'h0);
    rd(0, 'h00C, 32'h2, "R5 zero ack no effect");
    wr(1, 'h018, 32'h2);
    rd(0, 'h00C, 32'h0, "R5 ack ch1");

    // channels beyond count
    wr(0, 'h008, 32'h1 << 26);
    rd(0, 'h00C, 32'h0, "R12 ch10 not settable");

    // bank1 own flag
    wr(1, 'h018, 32'h1 << 16);
    rd(1, 'h01C, 32'h1, "R4 bank1 ch0 set");
    rd(0, 'h00C, 32'h0, "R4 bank0 unaffected");

    // set vs ack collision
    wr(0, 'h008, 32'h1 << 19);
    wr2('h008, 32'h1 << 19, 'h018, 32'h8);
    rd(0, 'h00C, 32'h8, "R10 set wins over ack");
    wr2('h01C, 32'h0, 'h018, 32'h8);
    rd(0, 'h00C, 32'h0, "R5 ack alone clears");

    // port priority on same word
    wr2('h010, 32'h1, 'h010, 32'h0001_0000);
    rd(1, 'h010, 32'h1, "R11 port0 wins enable");
    wr2('h014, 32'h0, 'h014, 32'hFFFF_FFFF);
    rd(0, 'h014, 32'h0, "R11 port0 wins mask");

    // tx gating
    wr(0, 'h000, 32'h1);
    chk_irq(4'h0, "R8 irq_tx0 disabled");

    repeat (4) @(negedge clk);
    done = 1;
    report();
  end
endmodule